// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block serves one completion queue. It sits between the logic that reports finished work and the logic that builds interrupt messages. It does not raise an interrupt for every completion. It collects completions into a batch and raises one interrupt request for the whole batch.

The request fires when either of two limits is reached, whichever comes first:
- the batch holds a programmed number of completions, or
- a programmed number of microsecond ticks has passed since the batch's first completion.

When the request fires, the completion count and the elapsed-time counter both restart. The request is a single-cycle pulse. It comes with the batch size, which stays on its output until the next request. After a request, the block raises no new request until the message generator acknowledges the current one. Completions that arrive during that wait are not dropped. They go into the next batch.

Each queue has its own instance, so each queue's request reaches only that queue's vector. Larger limits give fewer interrupts but longer completion latency. The usual settings are 16 completions and 100 microseconds. A frame limit of zero selects the default of 16, and a time limit of zero turns off the time trigger.

Top module: `cq_irq_coalescer`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_count` is 0.
- R2: When a `cmpl_evt` brings the batch count up to `frame_limit`, `irq_req` is 1 in the next cycle, and `irq_count` then equals the batch count.
- R3: With `frame_limit` = 1, each acknowledged completion produces its own request, with `irq_count` = 1.
- R4: A `frame_limit` of 0 behaves as a limit of 16 completions.
- R5: Timing rule for the time trigger:
  - The elapsed time counts `usec_tick` pulses that come after the cycle of the batch's first completion.
  - In the cycle where this count reaches a non-zero `usec_limit`, the request fires on the next cycle, even if the batch is below `frame_limit`.
  - `irq_count` then equals the number of completions in the batch.
- R6: A `usec_limit` of 0 disables the time trigger. With no completions arriving, any number of ticks leaves a partial batch unsignalled.
- R7: With no completions pending, the block never requests, and ticks do not advance the timer.
- R8: After a request, no further request is raised until `irq_ack` is seen. Completions received while waiting form the next batch, and none are lost. That batch may fire from the cycle after the acknowledge.
- R9: `irq_req` lasts exactly one cycle. `irq_count` holds its value until the next request.
- R10: When both limits are reached in the same cycle, exactly one request is raised.
- R11: An `irq_ack` while no request is outstanding has no effect on the outputs or on the batch being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_evt | input | 1 | One-cycle pulse per finished completion |
| frame_limit | input | CNT_W | Completions per batch; 0 selects 16 |
| usec_limit | input | TIME_W | Maximum batch age in microseconds; 0 disables |
| usec_tick | input | 1 | One-cycle pulse each microsecond |
| irq_ack | input | 1 | Message generator has taken the request |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_count | output | CNT_W | Number of completions in the signalled batch |

## Verification
The bench applies the following patterns:
- **Steady stream of completions, no ticks.** This isolates the count trigger. It is run with a limit of four, a limit of one and a limit of zero, which tells the programmed threshold apart from the default one.
- **Single completion followed by ticks.** This isolates the time trigger.
- **Ticks with nothing pending.** This shows whether the timer wrongly starts from idle.
- **Ticks against a partial batch with the time limit at zero.** This tells a disabled timer from a slow one.
- **Completions during the acknowledge wait.** This separates a block that loses them from one that carries them into the next batch.
- **A completion and a tick in the same cycle that meet both limits.** This checks that the block raises one request, not two.
- **Stray acknowledges.** These are shown to leave the outputs and the batch unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Batch limits that software is expected to program by default
    localparam int DEF_FRAMES = 16;
    localparam int DEF_USECS  = 100;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // nothing pending
        ST_GATHER = 2'd1,   // batch open, limits watched
        ST_WAIT   = 2'd2    // request issued, waiting for acknowledge
    } irqc_state_e;

    typedef struct packed {
        logic by_count;
        logic by_time;
    } irqc_hit_t;

    function automatic logic any_hit(input irqc_hit_t h);
        return h.by_count | h.by_time;
    endfunction

endpackage

// File: rtl/irqc_batch_count.sv
module irqc_batch_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clear,
    output logic [CNT_W-1:0] pend,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Saturating count including the completion of this cycle
    always_comb begin
        cnt_nxt = pend;
        if (evt && pend != CMAX)
            cnt_nxt = pend + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else if (clear)
            pend <= '0;
        else
            pend <= cnt_nxt;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pend == CMAX && !clear) |=> (pend == CMAX)); // R2

endmodule

// File: rtl/irqc_age_timer.sv
module irqc_age_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              running,
    input  logic              clear,
    output logic [TIME_W-1:0] elapsed,
    output logic [TIME_W-1:0] time_nxt
);
    localparam logic [TIME_W-1:0] TMAX = {TIME_W{1'b1}};

    always_comb begin
        time_nxt = elapsed;
        if (tick && running && elapsed != TMAX)
            time_nxt = elapsed + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            elapsed <= '0;
        else if (clear)
            elapsed <= '0;
        else
            elapsed <= time_nxt;
    end

    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !running |-> (elapsed == '0)); // R7

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [CNT_W-1:0]  pend,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [TIME_W-1:0] time_nxt,
    input  logic [CNT_W-1:0]  frame_limit,
    input  logic [TIME_W-1:0] usec_limit,
    input  logic              irq_ack,
    output logic              fire,
    output logic              irq_req,
    output logic [CNT_W-1:0]  irq_count
);
    localparam logic [CNT_W-1:0] FRAMES_DEF = CNT_W'(DEF_FRAMES);

    irqc_state_e      state, state_nxt;
    irqc_hit_t        hit;
    logic [CNT_W-1:0] frames_eff;

    assign frames_eff   = (frame_limit == '0) ? FRAMES_DEF : frame_limit;
    assign hit.by_count = (cnt_nxt != '0) && (cnt_nxt >= frames_eff);
    assign hit.by_time  = (usec_limit != '0) && (pend != '0) && (time_nxt >= usec_limit);
    assign fire         = (state != ST_WAIT) && any_hit(hit);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (fire) state_nxt = ST_WAIT;
                       else if (evt) state_nxt = ST_GATHER;
            ST_GATHER: if (fire) state_nxt = ST_WAIT;
            ST_WAIT:   if (irq_ack) state_nxt = (cnt_nxt != '0) ? ST_GATHER : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            irq_req   <= 1'b0;
            irq_count <= '0;
        end else begin
            state   <= state_nxt;
            irq_req <= fire;
            if (fire)
                irq_count <= cnt_nxt;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req); // R9
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> $stable(irq_count)); // R9
    AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_count != '0)); // R2
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !irq_ack) |=> !irq_req); // R8
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
        (irq_req && $past(usec_limit) == '0) |-> (irq_count >= $past(frames_eff))); // R2

endmodule

// File: rtl/cq_irq_coalescer.sv
module cq_irq_coalescer #(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmpl_evt,
    input  logic [CNT_W-1:0]  frame_limit,
    input  logic [TIME_W-1:0] usec_limit,
    input  logic              usec_tick,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [CNT_W-1:0]  irq_count
);
    logic              fire;
    logic [CNT_W-1:0]  pend, cnt_nxt;
    logic [TIME_W-1:0] elapsed, time_nxt;

    irqc_batch_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .evt     (cmpl_evt),
        .clear   (fire),
        .pend    (pend),
        .cnt_nxt (cnt_nxt)
    );

    irqc_age_timer #(.TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (usec_tick),
        .running  (pend != '0),
        .clear    (fire),
        .elapsed  (elapsed),
        .time_nxt (time_nxt)
    );

    irqc_ctrl #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt         (cmpl_evt),
        .pend        (pend),
        .cnt_nxt     (cnt_nxt),
        .time_nxt    (time_nxt),
        .frame_limit (frame_limit),
        .usec_limit  (usec_limit),
        .irq_ack     (irq_ack),
        .fire        (fire),
        .irq_req     (irq_req),
        .irq_count   (irq_count)
    );

    // elapsed is observed by the timer's own check only
    logic unused_elapsed;
    assign unused_elapsed = ^elapsed;

endmodule

// File: tb/cq_irq_coalescer_tb.sv
module cq_irq_coalescer_tb;
    localparam int CNT_W  = 8;
    localparam int TIME_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmpl_evt = 1'b0;
    logic [CNT_W-1:0]  frame_limit = '0;
    logic [TIME_W-1:0] usec_limit = '0;
    logic              usec_tick = 1'b0;
    logic              irq_ack = 1'b0;
    logic              irq_req;
    logic [CNT_W-1:0]  irq_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cq_irq_coalescer #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_dut (
        .clk(clk), .rst(rst), .cmpl_evt(cmpl_evt), .frame_limit(frame_limit),
        .usec_limit(usec_limit), .usec_tick(usec_tick), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_count(irq_count)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Inputs applied at a falling edge, result sampled at the next falling edge
    task automatic step(input logic e, input logic t, input logic a);
        cmpl_evt  = e;
        usec_tick = t;
        irq_ack   = a;
        @(negedge clk);
        cmpl_evt  = 1'b0;
        usec_tick = 1'b0;
        irq_ack   = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq_req", int'(irq_req), 0);
        check("R1 irq_count", int'(irq_count), 0);
    endtask

    task automatic t_frames();
        frame_limit = 8'd4; usec_limit = '0;
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0);
            check("R2 below limit", int'(irq_req), 0);
        end
        step(1, 0, 0);
        check("R2 fire at limit", int'(irq_req), 1);
        check("R2 batch size", int'(irq_count), 4);
        step(0, 0, 0);
        check("R9 pulse width", int'(irq_req), 0);
        check("R9 count held", int'(irq_count), 4);
        step(0, 0, 1);
    endtask

    task automatic t_single();
        frame_limit = 8'd1; usec_limit = '0;
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0);
            check("R3 one per completion", int'(irq_req), 1);
            check("R3 count one", int'(irq_count), 1);
            step(0, 0, 1);
            check("R3 low after", int'(irq_req), 0);
        end
    endtask

    task automatic t_default();
        frame_limit = '0; usec_limit = '0;
        for (int i = 0; i < 15; i++) begin
            step(1, 0, 0);
            check("R4 below default", int'(irq_req), 0);
        end
        step(1, 0, 0);
        check("R4 fire at 16", int'(irq_req), 1);
        check("R4 batch 16", int'(irq_count), 16);
        step(0, 0, 1);
    endtask

    task automatic t_time();
        frame_limit = 8'd10; usec_limit = 16'd3;
        step(1, 0, 0);
        check("R5 no fire on event", int'(irq_req), 0);
        step(0, 1, 0);
        check("R5 tick 1", int'(irq_req), 0);
        step(0, 1, 0);
        check("R5 tick 2", int'(irq_req), 0);
        step(0, 1, 0);
        check("R5 fire at tick 3", int'(irq_req), 1);
        check("R5 partial batch", int'(irq_count), 1);
        step(0, 0, 1);
    endtask

    task automatic t_time_off();
        int seen = 0;
        frame_limit = 8'd5; usec_limit = '0;
        step(1, 0, 0);
        step(1, 0, 0);
        for (int i = 0; i < 50; i++) begin
            step(0, 1, 0);
            seen += int'(irq_req);
        end
        check("R6 ticks ignored", seen, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        check("R6 count still fires", int'(irq_req), 1);
        check("R6 batch size", int'(irq_count), 5);
        step(0, 0, 1);
    endtask

    task automatic t_idle();
        int seen = 0;
        frame_limit = 8'd4; usec_limit = 16'd2;
        for (int i = 0; i < 20; i++) begin
            step(0, 1, 0);
            seen += int'(irq_req);
        end
        check("R7 idle never fires", seen, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        check("R7 timer fresh at tick 1", int'(irq_req), 0);
        step(0, 1, 0);
        check("R7 fire at tick 2", int'(irq_req), 1);
        check("R7 count", int'(irq_count), 1);
        step(0, 0, 1);
    endtask

    task automatic t_wait();
        frame_limit = 8'd2; usec_limit = '0;
        step(1, 0, 0);
        step(1, 0, 0);
        check("R8 first batch fires", int'(irq_req), 1);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0);
            check("R8 held while waiting", int'(irq_req), 0);
        end
        step(0, 0, 1);
        check("R8 ack cycle", int'(irq_req), 0);
        step(0, 0, 0);
        check("R8 next batch fires", int'(irq_req), 1);
        check("R8 none lost", int'(irq_count), 3);
        step(0, 0, 1);
    endtask

    task automatic t_both();
        int seen = 0;
        frame_limit = 8'd2; usec_limit = 16'd1;
        step(1, 0, 0);
        check("R10 not yet", int'(irq_req), 0);
        step(1, 1, 0);
        check("R10 fires", int'(irq_req), 1);
        check("R10 count", int'(irq_count), 2);
        step(0, 0, 0);
        check("R10 single pulse", int'(irq_req), 0);
        step(0, 0, 1);
        for (int i = 0; i < 5; i++) begin
            step(0, 1, 0);
            seen += int'(irq_req);
        end
        check("R10 no second request", seen, 0);
    endtask

    task automatic t_stray_ack();
        int held = int'(irq_count);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1);
            check("R11 stray ack req", int'(irq_req), 0);
            check("R11 stray ack count", int'(irq_count), held);
        end
        frame_limit = 8'd2; usec_limit = '0;
        step(1, 0, 0);
        step(0, 0, 1);
        check("R11 ack during batch", int'(irq_req), 0);
        step(1, 0, 0);
        check("R11 batch intact", int'(irq_req), 1);
        check("R11 batch count", int'(irq_count), 2);
        step(0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frames();
        t_single();
        t_default();
        t_time();
        t_time_off();
        t_idle();
        t_wait();
        t_both();
        t_stray_ack();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule